// File: doc/BRIEF.md
# Two-Stage Virtual Channel Allocator

This block hands out downstream virtual channels to packets waiting in the input virtual channels of a wormhole router. Each input VC that holds a buffered head flit with a computed output port raises a request naming that port and the number of flits it needs room for. The allocator looks at the virtual channels of that output port in the next router. It keeps those that are free and whose credit count covers the flit count. It then settles the result in two separable steps.

In the first step every requesting input VC picks one candidate downstream VC with its own round-robin pointer. In the second step every downstream VC picks one winner among the input VCs that chose it, again round-robin. Winners see a one-cycle grant that names the won VC within the port. From then on the downstream VC is owned until the router pulses its release line when the tail flit leaves. Losers are not stored. They keep their request raised and try again the next cycle.

Top module: `vc_alloc_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no grant is output. Reset frees every downstream VC, drops every ownership and sets every round-robin pointer so that the lowest index has the highest priority.
- R2: A request sampled at a rising edge produces its grant at the next rising edge. The grant lasts exactly one cycle. grantVc for that input carries the VC number within the requested port, and downstream VC d is port*VCS_PER_PORT+vc. grantVc reads 0 for inputs without a grant.
- R3: A downstream VC is a candidate only if its credit count is greater than or equal to the requested flit count. Equality is enough. With no such VC on the port, no grant is made.
- R4: A granted downstream VC is never granted again until its release bit has been pulsed. A release in the same cycle as a request does not make the VC available to that request.
- R5: A release pulse on downstream VC d frees it from the following cycle. It also frees the input VC that owned it so that it may request again.
- R6: In step one, each input VC chooses among its eligible downstream VCs round-robin. After a grant, its priority moves to the VC after the one it won. Without a grant, its priority does not move.
- R7: When several input VCs choose the same downstream VC, exactly one of them is granted. Each downstream VC keeps its own round-robin priority, which moves past the winner after every grant. The losers are retried whenever they hold their request.
- R8: An input VC that already owns a downstream VC receives no further grant while it keeps requesting.
- R9: A request naming a port number at or above NUM_PORTS is ignored and produces no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | NUM_PORTS*VCS_PER_PORT | Request per input VC |
| reqPort | input | NUM_PORTS*VCS_PER_PORT*PW | Routed output port per input VC, PW = clog2(NUM_PORTS) |
| reqFlits | input | NUM_PORTS*VCS_PER_PORT*CREDIT_W | Flit count that must fit downstream, per input VC |
| dsCredits | input | NUM_PORTS*VCS_PER_PORT*CREDIT_W | Credit count per downstream VC |
| vcRelease | input | NUM_PORTS*VCS_PER_PORT | Tail-departure pulse per downstream VC |
| grantValid | output | NUM_PORTS*VCS_PER_PORT | One-cycle grant per input VC |
| grantVc | output | NUM_PORTS*VCS_PER_PORT*VW | Won VC number within the port, VW = clog2(VCS_PER_PORT) |

## Verification
The bench targets three cases. The first is a release arriving in the same cycle as a waiting request: a design that forwarded the release would hand out the VC one cycle early, while its previous packet still occupied it. The second is a credit count equal to the flit count: an off-by-one compare would refuse a VC that fits. The third is a downstream VC whose priority pointer has already moved past a lower-numbered input. A design that used fixed priority, or advanced pointers on lost requests, would pick the wrong winner. The bench also floods one port from all ten inputs at once and checks that exactly two grants come out, to the inputs the rotating pointers predict. A broken second step would give two inputs the same VC. Finally, it checks that a holder which keeps requesting gets nothing further, which catches designs that forget ownership.

// File: rtl/vca_pkg.sv
package vca_pkg;

  localparam int unsigned DEF_PORTS    = 5;
  localparam int unsigned DEF_VCS      = 2;
  localparam int unsigned DEF_CREDIT_W = 4;

  // index width that never collapses to zero bits
  function automatic int unsigned idxWidth(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int unsigned IW = vca_pkg::idxWidth(N);

  logic [IW-1:0] ptr;
  logic [IW-1:0] winIdx;
  logic [IW-1:0] pos;
  logic          found;

  // scan from the pointer upward, wrapping, first request wins
  always_comb begin
    gnt    = '0;
    winIdx = '0;
    found  = 1'b0;
    pos    = '0;
    for (int k = 0; k < int'(N); k++) begin
      pos = IW'((int'(ptr) + k) % int'(N));
      if (!found && req[pos]) begin
        gnt[pos] = 1'b1;
        winIdx   = pos;
        found    = 1'b1;
      end
    end
  end

  // pointer moves past the winner only when the grant was used
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (adv && found) begin
      ptr <= (int'(winIdx) == int'(N) - 1) ? '0 : winIdx + IW'(1);
    end
  end

endmodule

// File: rtl/vca_control.sv
module vca_control #(
  parameter int unsigned NUM_PORTS = vca_pkg::DEF_PORTS,
  parameter int unsigned VCS       = vca_pkg::DEF_VCS,
  parameter int unsigned NIN       = NUM_PORTS * VCS,
  parameter int unsigned NOUT      = NUM_PORTS * VCS,
  parameter int unsigned PW        = vca_pkg::idxWidth(NUM_PORTS),
  parameter int unsigned VW        = vca_pkg::idxWidth(VCS),
  parameter int unsigned DW        = vca_pkg::idxWidth(NOUT)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NIN-1:0][VCS-1:0]   candMask,
  input  logic [NIN-1:0][PW-1:0]    reqPort,
  output logic [NIN-1:0]            grantIn,
  output logic [NIN-1:0][VW-1:0]    grantSel,
  output logic [NIN-1:0][DW-1:0]    grantDs
);

  logic [NIN-1:0][VCS-1:0] pickGnt;
  logic [NIN-1:0]          pickAny;
  logic [NIN-1:0][VW-1:0]  pickSel;
  logic [NIN-1:0][DW-1:0]  pickDs;
  logic [NOUT-1:0][NIN-1:0] askCol;
  logic [NOUT-1:0][NIN-1:0] winCol;
  logic [NOUT-1:0][NIN-1:0] ownCol;

  // step one: each input VC picks one downstream VC on its port
  for (genvar gi = 0; gi < NIN; gi++) begin : g_stepOne
    vca_rr_arb #(.N(VCS)) u_pick (
      .clk  (clk),
      .rstN (rstN),
      .req  (candMask[gi]),
      .adv  (grantIn[gi]),
      .gnt  (pickGnt[gi])
    );
  end

  always_comb begin
    for (int i = 0; i < int'(NIN); i++) begin
      pickAny[i] = |pickGnt[i];
      pickSel[i] = '0;
      for (int v = 0; v < int'(VCS); v++) begin
        if (pickGnt[i][v]) pickSel[i] = VW'(v);
      end
      pickDs[i] = DW'(int'(reqPort[i]) * int'(VCS) + int'(pickSel[i]));
    end
  end

  always_comb begin
    for (int d = 0; d < int'(NOUT); d++) begin
      for (int i = 0; i < int'(NIN); i++) begin
        askCol[d][i] = pickAny[i] && (int'(pickDs[i]) == d);
      end
    end
  end

  // step two: each downstream VC picks one winner among its askers
  for (genvar gd = 0; gd < NOUT; gd++) begin : g_stepTwo
    vca_rr_arb #(.N(NIN)) u_settle (
      .clk  (clk),
      .rstN (rstN),
      .req  (askCol[gd]),
      .adv  (|askCol[gd]),
      .gnt  (winCol[gd])
    );
  end

  always_comb begin
    for (int i = 0; i < int'(NIN); i++) begin
      grantIn[i] = 1'b0;
      for (int d = 0; d < int'(NOUT); d++) begin
        grantIn[i] = grantIn[i] | winCol[d][i];
      end
    end
  end

  assign grantSel = pickSel;
  assign grantDs  = pickDs;

  // who ends up owning each downstream VC this cycle
  always_comb begin
    for (int d = 0; d < int'(NOUT); d++) begin
      for (int i = 0; i < int'(NIN); i++) begin
        ownCol[d][i] = grantIn[i] && (int'(grantDs[i]) == d);
      end
    end
  end

  for (genvar gd = 0; gd < NOUT; gd++) begin : g_ownChk
    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(ownCol[gd]))
      else $error("two inputs granted downstream VC %0d", gd);
  end

endmodule

// File: rtl/vca_datapath.sv
module vca_datapath #(
  parameter int unsigned NUM_PORTS = vca_pkg::DEF_PORTS,
  parameter int unsigned VCS       = vca_pkg::DEF_VCS,
  parameter int unsigned CW        = vca_pkg::DEF_CREDIT_W,
  parameter int unsigned NIN       = NUM_PORTS * VCS,
  parameter int unsigned NOUT      = NUM_PORTS * VCS,
  parameter int unsigned PW        = vca_pkg::idxWidth(NUM_PORTS),
  parameter int unsigned VW        = vca_pkg::idxWidth(VCS),
  parameter int unsigned DW        = vca_pkg::idxWidth(NOUT)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NIN-1:0]           reqValid,
  input  logic [NIN-1:0][PW-1:0]   reqPort,
  input  logic [NIN-1:0][CW-1:0]   reqFlits,
  input  logic [NOUT-1:0][CW-1:0]  dsCredits,
  input  logic [NOUT-1:0]          vcRelease,
  input  logic [NIN-1:0]           grantIn,
  input  logic [NIN-1:0][VW-1:0]   grantSel,
  input  logic [NIN-1:0][DW-1:0]   grantDs,
  output logic [NIN-1:0][VCS-1:0]  candMask,
  output logic [NIN-1:0]           grantValid,
  output logic [NIN-1:0][VW-1:0]   grantVc
);

  logic [NOUT-1:0]         busy;
  logic [NIN-1:0]          held;
  logic [NIN-1:0][DW-1:0]  ownDs;
  logic [NIN-1:0]          portOk;
  logic [DW-1:0]           gIdx;

  // eligibility: live request, no current ownership, VC free, room for flits
  always_comb begin
    gIdx = '0;
    for (int i = 0; i < int'(NIN); i++) begin
      portOk[i] = int'(reqPort[i]) < int'(NUM_PORTS);
      for (int v = 0; v < int'(VCS); v++) begin
        candMask[i][v] = 1'b0;
        if (portOk[i] && reqValid[i] && !held[i]) begin
          gIdx = DW'(int'(reqPort[i]) * int'(VCS) + v);
          candMask[i][v] = !busy[gIdx] && (dsCredits[gIdx] >= reqFlits[i]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= '0;
      held       <= '0;
      ownDs      <= '0;
      grantValid <= '0;
      grantVc    <= '0;
    end else begin
      for (int d = 0; d < int'(NOUT); d++) begin
        if (vcRelease[d]) busy[d] <= 1'b0;
      end
      for (int i = 0; i < int'(NIN); i++) begin
        if (held[i] && vcRelease[ownDs[i]]) held[i] <= 1'b0;
        if (grantIn[i]) begin
          held[i]           <= 1'b1;
          ownDs[i]          <= grantDs[i];
          busy[grantDs[i]]  <= 1'b1;
        end
        grantValid[i] <= grantIn[i];
        grantVc[i]    <= grantIn[i] ? grantSel[i] : '0;
      end
    end
  end

  for (genvar gi = 0; gi < NIN; gi++) begin : g_chk
    p_target_free_r4: assert property (@(posedge clk) disable iff (!rstN)
      grantIn[gi] |-> !busy[grantDs[gi]])
      else $error("input %0d granted a busy VC", gi);

    p_credit_fit_r3: assert property (@(posedge clk) disable iff (!rstN)
      grantIn[gi] |-> (dsCredits[grantDs[gi]] >= reqFlits[gi]))
      else $error("input %0d granted VC without room", gi);

    p_grant_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[gi] |=> !grantValid[gi])
      else $error("input %0d grant lasted over one cycle", gi);

    p_no_regrant_r8: assert property (@(posedge clk) disable iff (!rstN)
      held[gi] |-> !grantIn[gi])
      else $error("input %0d granted while owning a VC", gi);

    p_legal_port_r9: assert property (@(posedge clk) disable iff (!rstN)
      grantIn[gi] |-> portOk[gi] && reqValid[gi])
      else $error("input %0d granted without a legal request", gi);
  end

endmodule

// File: rtl/vc_alloc_top.sv
module vc_alloc_top #(
  parameter int unsigned NUM_PORTS    = vca_pkg::DEF_PORTS,
  parameter int unsigned VCS_PER_PORT = vca_pkg::DEF_VCS,
  parameter int unsigned CREDIT_W     = vca_pkg::DEF_CREDIT_W,
  localparam int unsigned NIN  = NUM_PORTS * VCS_PER_PORT,
  localparam int unsigned NOUT = NUM_PORTS * VCS_PER_PORT,
  localparam int unsigned PW   = vca_pkg::idxWidth(NUM_PORTS),
  localparam int unsigned VW   = vca_pkg::idxWidth(VCS_PER_PORT)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NIN-1:0]           reqValid,
  input  logic [NIN*PW-1:0]        reqPort,
  input  logic [NIN*CREDIT_W-1:0]  reqFlits,
  input  logic [NOUT*CREDIT_W-1:0] dsCredits,
  input  logic [NOUT-1:0]          vcRelease,
  output logic [NIN-1:0]           grantValid,
  output logic [NIN*VW-1:0]        grantVc
);
  localparam int unsigned DW = vca_pkg::idxWidth(NOUT);

  logic [NIN-1:0][VCS_PER_PORT-1:0] candMask;
  logic [NIN-1:0]                   grantIn;
  logic [NIN-1:0][VW-1:0]           grantSel;
  logic [NIN-1:0][DW-1:0]           grantDs;

  vca_control #(
    .NUM_PORTS (NUM_PORTS),
    .VCS       (VCS_PER_PORT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .candMask (candMask),
    .reqPort  (reqPort),
    .grantIn  (grantIn),
    .grantSel (grantSel),
    .grantDs  (grantDs)
  );

  vca_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .VCS       (VCS_PER_PORT),
    .CW        (CREDIT_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqPort    (reqPort),
    .reqFlits   (reqFlits),
    .dsCredits  (dsCredits),
    .vcRelease  (vcRelease),
    .grantIn    (grantIn),
    .grantSel   (grantSel),
    .grantDs    (grantDs),
    .candMask   (candMask),
    .grantValid (grantValid),
    .grantVc    (grantVc)
  );

endmodule

// File: tb/vc_alloc_top_test.sv
module vc_alloc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 10;
  localparam int NOUT = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  reqValid = '0;
  logic [29:0] reqPort = '0;
  logic [39:0] reqFlits = '0;
  logic [39:0] dsCredits = {10{4'd4}};
  logic [9:0]  vcRelease = '0;
  logic [9:0]  grantValid;
  logic [9:0]  grantVc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_alloc_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqFlits(reqFlits), .dsCredits(dsCredits), .vcRelease(vcRelease),
    .grantValid(grantValid), .grantVc(grantVc)
  );

  typedef struct packed {
    logic [9:0] vld;
    logic [2:0] port;
    logic [9:0] rel;
    logic [9:0] expG;
    logic [9:0] expV;
  } row_t;

  // all credits 4, flit count 1; bit i = input VC i, rel bit d = downstream VC d
  localparam row_t ROWS [15] = '{
    '{10'b0000000001, 3'd0, 10'b0000000000, 10'b0000000001, 10'b0000000000}, // R2 first grant vc0
    '{10'b0000000011, 3'd0, 10'b0000000000, 10'b0000000010, 10'b0000000010}, // R8 holder skipped
    '{10'b0000000100, 3'd0, 10'b0000000000, 10'b0000000000, 10'b0000000000}, // R4 port full
    '{10'b0000000100, 3'd0, 10'b0000000001, 10'b0000000000, 10'b0000000000}, // R4 same-cycle release
    '{10'b0000000100, 3'd0, 10'b0000000000, 10'b0000000100, 10'b0000000000}, // R5 freed VC reused
    '{10'b0000000000, 3'd0, 10'b0000000011, 10'b0000000000, 10'b0000000000},
    '{10'b0000011000, 3'd1, 10'b0000000000, 10'b0000001000, 10'b0000000000}, // R7 conflict
    '{10'b0000010000, 3'd1, 10'b0000000000, 10'b0000010000, 10'b0000010000}, // R7 loser retries
    '{10'b0000000000, 3'd0, 10'b0000001100, 10'b0000000000, 10'b0000000000},
    '{10'b0000011000, 3'd1, 10'b0000000000, 10'b0000011000, 10'b0000001000}, // R6 rotation
    '{10'b0000000000, 3'd0, 10'b0000001100, 10'b0000000000, 10'b0000000000},
    '{10'b0001100000, 3'd2, 10'b0000000000, 10'b0000100000, 10'b0000000000},
    '{10'b0000000000, 3'd0, 10'b0000010000, 10'b0000000000, 10'b0000000000},
    '{10'b0001000010, 3'd2, 10'b0000000000, 10'b0001000000, 10'b0000000000}, // R7 pointer past in1
    '{10'b0000000000, 3'd0, 10'b0000010000, 10'b0000000000, 10'b0000000000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic setReqs(input logic [9:0] m, input int port, input int flits);
    for (int i = 0; i < NIN; i++) begin
      reqPort[i*3 +: 3]  = 3'(port);
      reqFlits[i*4 +: 4] = 4'(flits);
    end
    reqValid = m;
  endtask

  task automatic cycle;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle;
    reqValid  = '0;
    vcRelease = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(grantValid == '0, "R1 grant during reset", 32'(grantValid), 0);
    rstN = 1'b1;
    cycle();
    check(grantValid == '0, "R1 grant after reset", 32'(grantValid), 0);

    for (int r = 0; r < 15; r++) begin
      setReqs(ROWS[r].vld, int'(ROWS[r].port), 1);
      vcRelease = ROWS[r].rel;
      cycle();
      check(grantValid == ROWS[r].expG, $sformatf("R2 R4 R6 R7 row %0d grants", r),
            32'(grantValid), 32'(ROWS[r].expG));
      check(grantVc == ROWS[r].expV, $sformatf("R2 R6 row %0d vc", r),
            32'(grantVc), 32'(ROWS[r].expV));
    end
    idle();

    // R3: VC0 of port 4 has no credit, VC1 taken
    dsCredits[8*4 +: 4] = 4'd0;
    setReqs(10'b0100000000, 4, 1);
    cycle();
    check(grantValid == 10'b0100000000 && grantVc == 10'b0100000000,
          "R3 only credited VC", {grantValid, grantVc}, {10'b0100000000, 10'b0100000000});
    idle(); vcRelease = 10'b1000000000; cycle(); idle();

    dsCredits[9*4 +: 4] = 4'd2;
    setReqs(10'b0100000000, 4, 3);
    cycle();
    check(grantValid == '0, "R3 too few credits", 32'(grantValid), 0);

    dsCredits[8*4 +: 4] = 4'd3;
    cycle();
    check(grantValid == 10'b0100000000 && grantVc == '0,
          "R3 equal credits fit", {grantValid, grantVc}, {10'b0100000000, 10'b0});
    idle(); vcRelease = 10'b0100000000; cycle(); idle();
    dsCredits = {10{4'd4}};

    // R9: out-of-range ports
    setReqs(10'b0010000000, 5, 1);
    cycle();
    check(grantValid == '0, "R9 port 5 ignored", 32'(grantValid), 0);
    setReqs(10'b0010000000, 7, 1);
    cycle();
    check(grantValid == '0, "R9 port 7 ignored", 32'(grantValid), 0);
    idle();

    // R7 / R6: all ten inputs flood port 0
    setReqs(10'b1111111111, 0, 1);
    cycle();
    cnt = $countones(grantValid);
    check(cnt == 2, "R7 two grants for two VCs", 32'(cnt), 2);
    check(grantValid == 10'b0000001100 && grantVc == 10'b0000000100,
          "R6 R7 predicted winners", {grantValid, grantVc}, {10'b0000001100, 10'b0000000100});
    cycle();
    check(grantValid == '0, "R4 R8 flood held", 32'(grantValid), 0);
    idle(); vcRelease = 10'b0000000011; cycle(); idle();

    // R1: reset clears ownership, busy state and pointers
    setReqs(10'b0000000001, 0, 1);
    cycle();
    check(grantValid == 10'b0000000001 && grantVc == 10'b0000000001,
          "R6 in0 pointer at vc1", {grantValid, grantVc}, {10'b0000000001, 10'b0000000001});
    idle();
    rstN = 1'b0;
    cycle();
    check(grantValid == '0, "R1 mid-run reset", 32'(grantValid), 0);
    rstN = 1'b1;
    setReqs(10'b0000000001, 0, 1);
    cycle();
    check(grantValid == 10'b0000000001 && grantVc == '0,
          "R1 pointer and ownership cleared", {grantValid, grantVc}, {10'b0000000001, 10'b0});
    idle();
    cycle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule